// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block turns the system clock into the timing strobes a UART needs. Two dividers run in series. A small prescaler divides the system clock first. A 10-bit baud divisor then divides the prescaler output. Each output pulse of this chain is a sample tick. Every thirteenth sample tick marks the end of a serial bit, so one bit is 13 sample ticks long rather than the usual 16.

Software programs both divider values with a single register write. The new values are held in a shadow copy and take effect only at the next bit boundary, so a bit that is already in progress is never cut short. A busy flag stays high until the shadow copy has been applied.

The block also times a break. A break-length register sets the duration in bit times. Writing the start bit of the control register holds the break output high, which means the serial line is driven low, for that many bit boundaries. The start bit then clears itself, and a done strobe lasting one clock is raised.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, `busy`, `bit_tick`, `break_active` and `break_done` are all low. After reset, both divider fields act as zero.
- R2: A write to address 0 sets the prescale field from data bits 19:16 and the baud field from data bits 9:0. Each field holds its divide ratio minus one. Once the new values apply, `sub_tick` is a one-clock pulse every (P+1)·(D+1) clocks, and the first pulse comes (P+1)·(D+1) clocks after the change.
- R3: When both fields are zero, each field divides by one and `sub_tick` is high on every clock.
- R4: `bit_tick` is high together with every thirteenth `sub_tick`, so one bit lasts 13·(P+1)·(D+1) clocks.
- R5: A divisor write raises `busy` in the next cycle. The new values apply from the cycle after the next `bit_tick`, and `busy` drops in that same cycle.
- R6: A divisor write made while an earlier write is still pending replaces the shadow values. A write made in the very cycle of a `bit_tick` is deferred to the following boundary.
- R7: A write to address 1 loads the break length N from data bits 15:0. When no break is active, a write to address 2 with data bit 9 set raises `break_active` in the next cycle. `break_active` stays high through the max(N,1)-th following `bit_tick` and falls in the cycle after it.
- R8: `break_done` is high for exactly one clock, in the cycle in which `break_active` falls.
- R9: A write to address 2 has no effect while a break is active. A write to address 2 with data bit 9 clear has no effect at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divisor, 1 break length, 2 control |
| wr_data | input | 20 | Write data |
| sub_tick | output | 1 | Sample tick pulse |
| bit_tick | output | 1 | Bit boundary pulse |
| busy | output | 1 | A divisor update is pending |
| break_active | output | 1 | Break in progress; the serial line is held low |
| break_done | output | 1 | One-clock pulse when a break ends |

## Verification
The hardest case to reach is a divisor write that lands exactly in a bit-boundary cycle. In that cycle the write and the shadow transfer compete for the same registers. The bench tracks the bit phase in its own model, waits until the model reports the last clock of a bit, and only then drives the write so that it is sampled on that cycle. Back-to-back divisor writes and control writes made during a running break cover the other cases where a request must be replaced or ignored.

// File: rtl/btg_pkg.sv
package btg_pkg;
  localparam int OSR        = 13;  // sample ticks per bit
  localparam int PRE_LSB    = 16;  // prescale field position in the divisor word
  localparam int BRK_START  = 9;   // control bit that starts a break
  typedef enum logic [1:0] {
    REG_DIV = 2'd0,
    REG_BRK = 2'd1,
    REG_CTL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/btg_wrapcnt.sv
module btg_wrapcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;

  assign wrap = en && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (wrap)    cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/btg_divreg.sv
module btg_divreg #(
  parameter int PRE_W = 4,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PRE_W-1:0] new_pre,
  input  logic [DIV_W-1:0] new_div,
  input  logic             boundary,
  output logic [PRE_W-1:0] act_pre,
  output logic [DIV_W-1:0] act_div,
  output logic             busy
);
  logic [PRE_W-1:0] sh_pre_q, sh_pre_d, act_pre_q, act_pre_d;
  logic [DIV_W-1:0] sh_div_q, sh_div_d, act_div_q, act_div_d;
  logic             pend_q, pend_d;

  always_comb begin
    sh_pre_d  = sh_pre_q;
    sh_div_d  = sh_div_q;
    act_pre_d = act_pre_q;
    act_div_d = act_div_q;
    pend_d    = pend_q;
    if (load) begin
      sh_pre_d = new_pre;
      sh_div_d = new_div;
      pend_d   = 1'b1;
    end else if (pend_q && boundary) begin
      act_pre_d = sh_pre_q;
      act_div_d = sh_div_q;
      pend_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pre_q  <= '0;
      sh_div_q  <= '0;
      act_pre_q <= '0;
      act_div_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      sh_pre_q  <= sh_pre_d;
      sh_div_q  <= sh_div_d;
      act_pre_q <= act_pre_d;
      act_div_q <= act_div_d;
      pend_q    <= pend_d;
    end
  end

  assign act_pre = act_pre_q;
  assign act_div = act_div_q;
  assign busy    = pend_q;
endmodule

// File: rtl/btg_break.sv
module btg_break #(
  parameter int BRK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [BRK_W-1:0] len_val,
  input  logic             start_req,
  input  logic             bit_tick,
  output logic             active,
  output logic             done
);
  logic [BRK_W-1:0] len_q, len_d, rem_q, rem_d;
  logic             act_q, act_d, done_q, done_d;

  always_comb begin
    len_d  = len_wr ? len_val : len_q;
    rem_d  = rem_q;
    act_d  = act_q;
    done_d = 1'b0;
    if (act_q) begin
      if (bit_tick) begin
        if (rem_q <= BRK_W'(1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          rem_d = rem_q - 1'b1;
        end
      end
    end else if (start_req) begin
      act_d = 1'b1;
      rem_d = len_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      rem_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      len_q  <= len_d;
      rem_q  <= rem_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign active = act_q;
  assign done   = done_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import btg_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int DIV_W  = 10,
  parameter int BRK_W  = 16,
  localparam int DATA_W = PRE_LSB + PRE_W,
  localparam int OSR_W  = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sub_tick,
  output logic              bit_tick,
  output logic              busy,
  output logic              break_active,
  output logic              break_done
);
  logic [PRE_W-1:0] act_pre;
  logic [DIV_W-1:0] act_div;
  logic             pre_tick;
  logic             wr_div, wr_brk, wr_ctl_start;

  assign wr_div       = wr_en && (wr_addr == REG_DIV);
  assign wr_brk       = wr_en && (wr_addr == REG_BRK);
  assign wr_ctl_start = wr_en && (wr_addr == REG_CTL) && wr_data[BRK_START];

  btg_divreg #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_divreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_div),
    .new_pre  (wr_data[PRE_LSB +: PRE_W]),
    .new_div  (wr_data[DIV_W-1:0]),
    .boundary (bit_tick),
    .act_pre  (act_pre),
    .act_div  (act_div),
    .busy     (busy)
  );

  btg_wrapcnt #(.W(PRE_W)) u_prescale (
    .clk (clk), .rst_n (rst_n), .en (1'b1), .limit (act_pre), .wrap (pre_tick)
  );

  btg_wrapcnt #(.W(DIV_W)) u_baud (
    .clk (clk), .rst_n (rst_n), .en (pre_tick), .limit (act_div), .wrap (sub_tick)
  );

  btg_wrapcnt #(.W(OSR_W)) u_phase (
    .clk (clk), .rst_n (rst_n), .en (sub_tick), .limit (OSR_W'(OSR - 1)), .wrap (bit_tick)
  );

  btg_break #(.BRK_W(BRK_W)) u_break (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_wr    (wr_brk),
    .len_val   (wr_data[BRK_W-1:0]),
    .start_req (wr_ctl_start),
    .bit_tick  (bit_tick),
    .active    (break_active),
    .done      (break_done)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       sub_tick,
  input logic       bit_tick,
  input logic       busy,
  input logic       break_active,
  input logic       break_done
);
  a_r4_bit_with_sub: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sub_tick);

  a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> busy);

  a_r5_busy_drops_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_tick));

  a_r7_break_holds_between_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (break_active && !bit_tick) |=> break_active);

  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(break_active) |-> break_done);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    break_done |=> !break_done);

  a_r8_done_only_after_break: assert property (@(posedge clk) disable iff (!rst_n)
    break_done |-> !break_active);
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .sub_tick     (sub_tick),
  .bit_tick     (bit_tick),
  .busy         (busy),
  .break_active (break_active),
  .break_done   (break_done)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  localparam int NSUB = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [19:0] wr_data = '0;
  logic        sub_tick, bit_tick, busy, break_active, break_done;

  int n_chk = 0;
  int n_fail = 0;
  string tag_div = "R3";
  string tag_brk = "R7";

  // behavioural reference state
  int m_pre = 0, m_div = 0, s_pre = 0, s_div = 0, m_ph = 0, m_rem = 0, m_len = 0;
  bit m_pend = 0, m_brk = 0, m_done = 0;

  baud_tick_gen u_baud_tick_gen (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .sub_tick (sub_tick), .bit_tick (bit_tick),
    .busy (busy), .break_active (break_active), .break_done (break_done)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int period();
    return (m_pre + 1) * (m_div + 1);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_div = 0; s_pre = 0; s_div = 0; m_ph = 0;
      m_pend = 0; m_brk = 0; m_done = 0; m_rem = 0; m_len = 0;
    end else begin
      int per, last;
      bit bt;
      per  = period();
      last = NSUB * per - 1;
      bt   = (m_ph == last);
      chk(tag_div, "sub_tick", sub_tick, ((m_ph + 1) % per) == 0);
      chk("R4", "bit_tick", bit_tick, bt);
      chk("R5", "busy", busy, m_pend);
      chk(tag_brk, "break_active", break_active, m_brk);
      chk("R8", "break_done", break_done, m_done);
      // advance model to the next cycle
      m_done = 0;
      if (m_brk) begin
        if (bt) begin
          if (m_rem <= 1) begin m_brk = 0; m_done = 1; end
          else m_rem--;
        end
      end else if (wr_en && wr_addr == 2'd2 && wr_data[9]) begin
        m_brk = 1; m_rem = m_len;
      end
      if (wr_en && wr_addr == 2'd1) m_len = int'(wr_data[15:0]);
      if (wr_en && wr_addr == 2'd0) begin
        s_pre = int'(wr_data[19:16]); s_div = int'(wr_data[9:0]); m_pend = 1;
      end else if (m_pend && bt) begin
        m_pre = s_pre; m_div = s_div; m_pend = 0;
      end
      m_ph = bt ? 0 : m_ph + 1;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [19:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // R6: drive a divisor write sampled in the last clock of a bit
  task automatic wr_on_boundary(input logic [19:0] d);
    bit hit = 0;
    while (!hit) begin
      @(posedge clk); #1;
      if (m_ph == NSUB * period() - 1) hit = 1;
    end
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "bit_tick in reset", bit_tick, 1'b0);
    chk("R1", "break_active in reset", break_active, 1'b0);
    chk("R1", "break_done in reset", break_done, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    tag_div = "R3";
    idle(40);
    tag_div = "R2";
    wr(2'd0, 20'h1_0002);          // prescale /2, baud /3
    idle(200);
    tag_div = "R6";
    wr(2'd0, 20'h0_0004);
    wr(2'd0, 20'h2_0000);          // replaces pending value
    idle(250);
    wr_on_boundary(20'h0_0001);
    idle(150);
    tag_div = "R3";
    wr(2'd0, 20'h0_0000);
    idle(100);
    tag_brk = "R7";
    wr(2'd1, 20'h0_0003);
    wr(2'd2, 20'h0_0200);
    idle(5);
    tag_brk = "R9";
    wr(2'd2, 20'h0_0200);          // ignored while active
    wr(2'd2, 20'h0_0000);
    idle(60);
    wr(2'd1, 20'h0_0000);
    wr(2'd2, 20'h0_0000);          // bit 9 clear: no break
    idle(20);
    tag_brk = "R7";
    wr(2'd2, 20'h0_0200);          // zero length acts as one bit
    idle(40);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule